// File: doc/BRIEF.md
# Oscillator Ratio Meter

This block measures how fast one oscillator runs compared with a reference. It holds two 16-bit counters. One of them is the gate counter: it counts a programmable number of pulses from its source and then closes the window. The other is the accumulating counter: it counts pulses from the other source for as long as the window is open. The oscillator side is picked from three candidate paths: the intermediate-frequency oscillator, the stereo-decoder oscillator and the RF oscillator divided by sixteen. A routing control decides which counter each source drives. All source pulses are single-cycle enables that are synchronous to `clk`.

A host measures in a fixed order. It presets both counters, clears, sets the window length and the routing, and raises the count enable. It then waits for `ready` and reads either counter through `result`. A control state machine has four states:
- IDLE: waiting, with nothing counted.
- COUNT: the window is open.
- DONE: the window has closed and both counters are frozen.
- HOLD: preset is active.

The transitions are as follows:
- IDLE→COUNT when `count_en` is 1.
- COUNT→IDLE when `count_en` falls.
- COUNT→DONE on the pulse that completes the gate count.
- Any state→HOLD while `preset` is 1.
- HOLD→IDLE when `preset` falls.
- Any other state→IDLE on `clear`.

Preset has priority over clear.

Top module: `osc_ratio_meter`

## Requirements
- R1: With gate code c on `gate_code`, `ready` rises on the clock edge that counts the gate counter's 2·4^c-th pulse. The code values 0 to 7 give 2, 8, 32, 128, 512, 2048, 8192 and 32768 pulses.
- R2: With `direct_map` = 1, the oscillator source drives counter 1 and `ref_pulse` drives counter 2. With `direct_map` = 0, `ref_pulse` drives counter 1 and the oscillator source drives counter 2. Counter 2 is always the gate counter.
- R3: Pulses are counted only in the COUNT state while `count_en` is 1. The edge that moves the block from IDLE to COUNT counts nothing. With `count_en` at 0, neither counter changes.
- R4: `result` shows counter 1 when `read_sel` = 0 and counter 2 when `read_sel` = 1. The mux is combinational.
- R5: While `preset` is 1, both counters read FFFFh one cycle later and stay there, whatever pulses arrive. `ready` reads 0.
- R6: `clear` (when `preset` is 0) sets counter 1 to 0 and clears `ready` and `overflow` one cycle later. Counter 2 keeps its value.
- R7: Counter 1 stepping from FFFFh to 0000h sets `overflow`. The flag stays set until a clear. A wrap of counter 2 sets no flag.
- R8: `ready` is 0 until the gate count completes. After that, `ready` stays 1 and both counters hold until a clear or a preset.
- R9: `src_sel` is one-hot: bit 0 picks the IF path, bit 1 the stereo-decoder path and bit 2 the RF/16 path. With zero bits or more than one bit set, no oscillator pulse reaches either counter.
- R10: After reset, both counters are 0, `ready` and `overflow` are 0, and the block is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_if_pulse | input | 1 | Single-cycle pulse from the IF oscillator path |
| osc_sd_pulse | input | 1 | Single-cycle pulse from the stereo-decoder oscillator path |
| osc_rf16_pulse | input | 1 | Single-cycle pulse from the RF/16 path |
| ref_pulse | input | 1 | Single-cycle pulse from the reference source |
| src_sel | input | 3 | One-hot oscillator path select |
| gate_code | input | 3 | Window length code |
| direct_map | input | 1 | 1: oscillator to counter 1; 0: oscillator to counter 2 |
| count_en | input | 1 | Count enable |
| read_sel | input | 1 | Result select: 0 counter 1, 1 counter 2 |
| preset | input | 1 | Force and hold both counters at all ones |
| clear | input | 1 | Zero counter 1 and both flags |
| result | output | 16 | Selected counter value |
| ready | output | 1 | Window complete |
| overflow | output | 1 | Counter 1 has wrapped |

## Verification
Every registered result is due on the first rising edge after the edge that samples the stimulus. This covers counter values, `ready`, `overflow`, and the effects of preset and clear. Raising `count_en` costs one extra edge, because counting starts only once the state has moved to COUNT. `result` follows `read_sel` within the same cycle. The bench changes inputs a quarter period after a rising edge. It checks after exactly one edge, or after the extra edge for enable, and each check is queued and compared before the next edge arrives.

// File: rtl/ofm_pkg.sv
`timescale 1ns/1ps
package ofm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2,
        ST_HOLD  = 2'd3
    } ofm_state_e;

    localparam int OSC_PATHS = 3;
endpackage

// File: rtl/ofm_src_router.sv
`timescale 1ns/1ps
module ofm_src_router #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] osc_pulse,
    input  logic [NSRC-1:0] src_sel,
    input  logic            ref_pulse,
    input  logic            direct_map,
    output logic            c1_pulse,
    output logic            c2_pulse
);
    logic            legal;
    logic [NSRC-1:0] gated;
    logic            picked;

    assign legal = $onehot(src_sel);

    for (genvar g = 0; g < NSRC; g++) begin : g_pick
        assign gated[g] = osc_pulse[g] & src_sel[g] & legal;
    end

    assign picked = |gated;

    always_comb begin
        if (direct_map) begin
            c1_pulse = picked;
            c2_pulse = ref_pulse;
        end else begin
            c1_pulse = ref_pulse;
            c2_pulse = picked;
        end
    end

    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$onehot(src_sel) |-> !(direct_map ? c1_pulse : c2_pulse)); // R9
endmodule

// File: rtl/ofm_counter.sv
`timescale 1ns/1ps
module ofm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_ones,
    input  logic         zero,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        value <= '0;
        else if (set_ones) value <= '1;
        else if (zero)     value <= '0;
        else if (inc)      value <= value + W'(1);
    end

    assign wrap = inc && !set_ones && !zero && (&value);
endmodule

// File: rtl/osc_ratio_meter.sv
`timescale 1ns/1ps
module osc_ratio_meter
    import ofm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_if_pulse,
    input  logic              osc_sd_pulse,
    input  logic              osc_rf16_pulse,
    input  logic              ref_pulse,
    input  logic [OSC_PATHS-1:0] src_sel,
    input  logic [CODE_W-1:0] gate_code,
    input  logic              direct_map,
    input  logic              count_en,
    input  logic              read_sel,
    input  logic              preset,
    input  logic              clear,
    output logic [CNT_W-1:0]  result,
    output logic              ready,
    output logic              overflow
);
    localparam int LIM_W = CNT_W + 1;

    ofm_state_e       state_q, state_d;
    logic             c1_pulse, c2_pulse;
    logic [CNT_W-1:0] c1_val, c2_val, tally;
    logic             c1_wrap, c2_wrap;
    logic             clr_eff, cnt_ok, inc1, inc2, gate_hit;
    logic [LIM_W-1:0] limit;

    ofm_src_router #(.NSRC(OSC_PATHS)) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_pulse  ({osc_rf16_pulse, osc_sd_pulse, osc_if_pulse}),
        .src_sel    (src_sel),
        .ref_pulse  (ref_pulse),
        .direct_map (direct_map),
        .c1_pulse   (c1_pulse),
        .c2_pulse   (c2_pulse)
    );

    assign clr_eff  = clear && !preset;
    assign cnt_ok   = !preset && !clear && (state_q == ST_COUNT) && count_en;
    assign inc1     = cnt_ok && c1_pulse;
    assign inc2     = cnt_ok && c2_pulse;
    assign limit    = LIM_W'(2) << (2 * gate_code);
    assign gate_hit = inc2 && (({1'b0, tally} + LIM_W'(1)) == limit);

    ofm_counter #(.W(CNT_W)) u_cnt1 (
        .clk(clk), .rst_n(rst_n), .set_ones(preset), .zero(clr_eff),
        .inc(inc1), .value(c1_val), .wrap(c1_wrap)
    );

    ofm_counter #(.W(CNT_W)) u_cnt2 (
        .clk(clk), .rst_n(rst_n), .set_ones(preset), .zero(1'b0),
        .inc(inc2), .value(c2_val), .wrap(c2_wrap)
    );

    // gate pulse tally, restarted by preset or clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                tally <= '0;
        else if (preset || clear)  tally <= '0;
        else if (inc2)             tally <= tally + CNT_W'(1);
    end

    // sticky wrap flag of the accumulating counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        overflow <= 1'b0;
        else if (clr_eff)  overflow <= 1'b0;
        else if (c1_wrap)  overflow <= 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (preset) begin
            state_d = ST_HOLD;
        end else if (clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (count_en) state_d = ST_COUNT;
                ST_COUNT: begin
                    if (gate_hit)       state_d = ST_DONE;
                    else if (!count_en) state_d = ST_IDLE;
                end
                ST_DONE:  state_d = ST_DONE;
                ST_HOLD:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready  = (state_q == ST_DONE);
        result = read_sel ? c2_val : c1_val;
    end

    AST_PRESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (c1_val == '1 && c2_val == '1 && !ready)); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !preset) |=> (c1_val == '0 && !overflow && !ready)); // R6
    AST_DISABLED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !preset && !clear) |=> ($stable(c1_val) && $stable(c2_val))); // R3
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !preset && !clear) |=> (ready && $stable(c1_val) && $stable(c2_val))); // R8
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        c1_wrap |=> overflow); // R7
    AST_GATE_WRAP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (c2_wrap && !c1_wrap && !overflow) |=> !overflow); // R7
endmodule

// File: tb/sim_osc_ratio_meter.sv
`timescale 1ns/1ps
module sim_osc_ratio_meter;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_if_pulse = 1'b0, osc_sd_pulse = 1'b0, osc_rf16_pulse = 1'b0;
    logic        ref_pulse = 1'b0;
    logic [2:0]  src_sel = 3'b000;
    logic [2:0]  gate_code = 3'd0;
    logic        direct_map = 1'b1;
    logic        count_en = 1'b0;
    logic        read_sel = 1'b0;
    logic        preset = 1'b0;
    logic        clear = 1'b0;
    logic [15:0] result;
    logic        ready, overflow;

    always #(CLK_P/2) clk = ~clk;

    osc_ratio_meter u0 (
        .clk(clk), .rst_n(rst_n),
        .osc_if_pulse(osc_if_pulse), .osc_sd_pulse(osc_sd_pulse),
        .osc_rf16_pulse(osc_rf16_pulse), .ref_pulse(ref_pulse),
        .src_sel(src_sel), .gate_code(gate_code), .direct_map(direct_map),
        .count_en(count_en), .read_sel(read_sel), .preset(preset), .clear(clear),
        .result(result), .ready(ready), .overflow(overflow)
    );

    typedef struct {
        string       req;
        logic [15:0] res;
        logic        rdy;
        logic        ovf;
    } exp_t;

    exp_t sb_q[$];
    event sb_ev;
    int   n_run = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    // monitor: pops expectations and compares with the ports
    always @(sb_ev) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (result !== e.res || ready !== e.rdy || overflow !== e.ovf) begin
                n_fail++;
                $display("FAIL %s: result=%h exp %h, ready=%b exp %b, overflow=%b exp %b",
                         e.req, result, e.res, ready, e.rdy, overflow, e.ovf);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLK_P/4);
    endtask

    // driver: select the view, push the expected item, wake the monitor
    task automatic chk(string req, logic sel, logic [15:0] r, logic rd, logic ov);
        exp_t e;
        read_sel = sel;
        #0.1;
        e.req = req; e.res = r; e.rdy = rd; e.ovf = ov;
        sb_q.push_back(e);
        -> sb_ev;
        #0.1;
    endtask

    // bit 0 IF, bit 1 stereo decoder, bit 2 RF/16
    task automatic edge_cyc(logic [2:0] ob, logic r);
        {osc_rf16_pulse, osc_sd_pulse, osc_if_pulse} = ob;
        ref_pulse = r;
        tick();
        {osc_rf16_pulse, osc_sd_pulse, osc_if_pulse} = 3'b000;
        ref_pulse = 1'b0;
    endtask

    task automatic run_gate(logic [2:0] code);
        int lim;
        lim = 2 << (2 * code);
        preset = 1'b1; tick();
        preset = 1'b0; clear = 1'b1; tick();
        clear = 1'b0;
        direct_map = 1'b1; src_sel = 3'b001; gate_code = code; count_en = 1'b1;
        tick();
        for (int i = 0; i < lim - 1; i++) edge_cyc(3'b001, 1'b1);
        chk($sformatf("R1 code %0d one pulse short", code), 1'b0, 16'(lim - 1), 1'b0, 1'b0);
        edge_cyc(3'b001, 1'b1);
        chk($sformatf("R1 code %0d window closed", code), 1'b0, 16'(lim), 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R10 reset counter 1", 1'b0, 16'h0000, 1'b0, 1'b0);
        chk("R10 reset counter 2", 1'b1, 16'h0000, 1'b0, 1'b0);

        // basic window, code 0
        src_sel = 3'b001; direct_map = 1'b1; gate_code = 3'd0; count_en = 1'b1;
        edge_cyc(3'b001, 1'b1);
        chk("R3 enabling edge counts nothing c1", 1'b0, 16'h0000, 1'b0, 1'b0);
        chk("R3 enabling edge counts nothing c2", 1'b1, 16'h0000, 1'b0, 1'b0);
        repeat (3) edge_cyc(3'b001, 1'b0);
        chk("R3 oscillator pulses counted", 1'b0, 16'd3, 1'b0, 1'b0);
        edge_cyc(3'b001, 1'b1);
        chk("R8 not ready after one gate pulse", 1'b0, 16'd4, 1'b0, 1'b0);
        chk("R4 select shows counter 2", 1'b1, 16'd1, 1'b0, 1'b0);
        edge_cyc(3'b001, 1'b1);
        chk("R1 code 0 closes after 2", 1'b0, 16'd5, 1'b1, 1'b0);
        repeat (2) edge_cyc(3'b001, 1'b1);
        chk("R8 frozen c1", 1'b0, 16'd5, 1'b1, 1'b0);
        chk("R8 frozen c2", 1'b1, 16'd2, 1'b1, 1'b0);

        // clear
        clear = 1'b1; tick(); clear = 1'b0;
        chk("R6 clear zeroes c1 and ready", 1'b0, 16'd0, 1'b0, 1'b0);
        chk("R6 clear keeps c2", 1'b1, 16'd2, 1'b0, 1'b0);

        // code 1
        gate_code = 3'd1; tick();
        repeat (7) edge_cyc(3'b001, 1'b1);
        chk("R1 code 1 seven of eight", 1'b0, 16'd7, 1'b0, 1'b0);
        edge_cyc(3'b001, 1'b1);
        chk("R1 code 1 closes after 8", 1'b0, 16'd8, 1'b1, 1'b0);
        chk("R4 counter 2 after window", 1'b1, 16'd10, 1'b1, 1'b0);

        // preset
        preset = 1'b1; tick();
        chk("R5 preset c1 ones", 1'b0, 16'hFFFF, 1'b0, 1'b0);
        chk("R5 preset c2 ones", 1'b1, 16'hFFFF, 1'b0, 1'b0);
        edge_cyc(3'b001, 1'b1);
        chk("R5 held under pulses", 1'b0, 16'hFFFF, 1'b0, 1'b0);
        preset = 1'b0; tick();
        chk("R5 value kept after release", 1'b1, 16'hFFFF, 1'b0, 1'b0);

        // overflow
        gate_code = 3'd2; tick();
        edge_cyc(3'b001, 1'b0);
        chk("R7 wrap sets overflow", 1'b0, 16'd0, 1'b0, 1'b1);
        edge_cyc(3'b001, 1'b0);
        chk("R7 overflow sticky", 1'b0, 16'd1, 1'b0, 1'b1);
        clear = 1'b1; tick(); clear = 1'b0;
        chk("R7 clear drops overflow", 1'b0, 16'd0, 1'b0, 1'b0);

        // swapped routing
        direct_map = 1'b0; gate_code = 3'd0; tick();
        repeat (3) edge_cyc(3'b000, 1'b1);
        chk("R2 swapped ref drives c1", 1'b0, 16'd3, 1'b0, 1'b0);
        chk("R2 swapped c2 untouched by ref", 1'b1, 16'hFFFF, 1'b0, 1'b0);
        edge_cyc(3'b001, 1'b0);
        chk("R2 oscillator drives c2, wrap silent", 1'b1, 16'd0, 1'b0, 1'b0);
        edge_cyc(3'b001, 1'b0);
        chk("R2 gate closed on oscillator", 1'b1, 16'd1, 1'b1, 1'b0);

        // source select
        clear = 1'b1; direct_map = 1'b1; src_sel = 3'b011; tick();
        clear = 1'b0; tick();
        repeat (3) edge_cyc(3'b111, 1'b0);
        chk("R9 two bits route nothing", 1'b0, 16'd0, 1'b0, 1'b0);
        src_sel = 3'b000;
        edge_cyc(3'b111, 1'b0);
        chk("R9 no bit routes nothing", 1'b0, 16'd0, 1'b0, 1'b0);
        src_sel = 3'b100;
        repeat (2) edge_cyc(3'b100, 1'b0);
        edge_cyc(3'b011, 1'b0);
        chk("R9 RF16 path only", 1'b0, 16'd2, 1'b0, 1'b0);
        src_sel = 3'b010;
        edge_cyc(3'b010, 1'b0);
        edge_cyc(3'b001, 1'b0);
        chk("R9 stereo-decoder path only", 1'b0, 16'd3, 1'b0, 1'b0);

        // enable off
        count_en = 1'b0;
        edge_cyc(3'b010, 1'b1);
        chk("R3 disabled c1 still", 1'b0, 16'd3, 1'b0, 1'b0);
        chk("R3 disabled c2 still", 1'b1, 16'd1, 1'b0, 1'b0);
        count_en = 1'b1; tick();
        edge_cyc(3'b010, 1'b0);
        chk("R3 resumes after re-enable", 1'b0, 16'd4, 1'b0, 1'b0);

        // longer windows
        run_gate(3'd3);
        run_gate(3'd7);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run still active, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule